// File: doc/BRIEF.md
# Bang-Bang Phase Vote Detector

This block sits behind a 2x-oversampling receiver front end whose samples have already been deserialized into parallel words. Each word carries one data sample and one edge sample per lane. The edge sample of a lane is taken halfway between that lane's data sample and the data sample after it. For every lane where the two surrounding data samples differ, the block casts one vote. The vote is "early" when the edge sample equals the earlier data sample and "late" when it equals the later one. Lanes with no data transition do not vote. The net count (early minus late) leaves the block as a registered sign-magnitude code, for a downstream loop filter to integrate.

The last lane of a word needs the first data sample of the following word. The block therefore keeps one word in a holding register and scores it when the next valid word arrives. A small two-state controller tracks whether a word is held. In state `HOLD_EMPTY` (after reset) no word is held, and an input strobe takes the transition *prime*: the word is stored, nothing is emitted, and the state becomes `HOLD_FULL`. In state `HOLD_FULL` an input strobe takes the transition *emit*: the held word is scored against the new word's lane 0, the result is registered, and the new word replaces the held one while the state stays `HOLD_FULL`. Without a strobe, either state stays where it is (*idle*). Only reset returns the controller to `HOLD_EMPTY`.

Top module: `bbvote_detector`

## Requirements
- R1: A synchronous reset sets `vote_code` to 0000, deasserts `vote_valid` and puts the controller in `HOLD_EMPTY`.
- R2: The first `in_valid` strobe after reset (prime) stores the word and produces no `vote_valid` pulse.
- R3: Every later `in_valid` strobe (emit) causes `vote_valid` to be high on the cycle after the edge that samples the strobe. The code carried is the score of the previously stored word. `vote_valid` is never high otherwise.
- R4: A lane whose data sample differs from the next data sample, and whose edge sample equals its own data sample, adds +1 (early).
- R5: A lane whose data sample differs from the next data sample, and whose edge sample equals that next data sample, adds -1 (late).
- R6: A lane whose data sample equals the next data sample contributes 0, whatever its edge sample is.
- R7: For lane 3, the "next data sample" is `in_data[0]` of the following valid word.
- R8: The code is sign-magnitude. Bit 3 is set only for negative totals, and bits 2:0 hold the absolute value. Zero is always 0000: for example +4 = 0100, +1 = 0001, -1 = 1001, -4 = 1100.
- R9: While no result is emitted, `vote_code` keeps its last value. Idle cycles do not change which word is held.
- R10: The magnitude field never exceeds the lane count (4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe marking a new sample word |
| in_data | input | 4 | Data samples; bit 0 is the earliest in time |
| in_phase | input | 4 | Edge samples; bit n lies between data bits n and n+1 |
| vote_valid | output | 1 | One-cycle pulse marking a new vote code |
| vote_code | output | 4 | Net early-minus-late vote, sign-magnitude |

## Verification
Patterns where every lane toggles, with all edges matching the earlier sample or all matching the later one, drive the extremes +4 and -4 and separate the two voting rules and the sign bit. Words without toggles but with mixed edge samples show that non-transition lanes are silenced. Words whose only toggle is at the word boundary isolate the cross-word use of the next word's lane 0. A sweep over all data/edge combinations, with varied successor bits and interleaved idle cycles, checks every total against an arithmetic count and confirms that idle cycles neither emit nor disturb the held word. A reset in mid-stream confirms that priming restarts.

// File: rtl/bbvote_pkg.sv
`timescale 1ns/1ps
package bbvote_pkg;
    typedef enum logic {
        HOLD_EMPTY = 1'b0,
        HOLD_FULL  = 1'b1
    } hold_state_t;
endpackage

// File: rtl/bbvote_hold.sv
`timescale 1ns/1ps
module bbvote_hold
    import bbvote_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [LANES-1:0] in_data,
    input  logic [LANES-1:0] in_phase,
    output logic [LANES-1:0] held_data,
    output logic [LANES-1:0] held_phase,
    output hold_state_t      state,
    output logic             fire
);
    hold_state_t state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= HOLD_EMPTY;
        else     state <= state_nx;
    end

    // next state and emit strobe
    always_comb begin
        state_nx = state;
        fire     = 1'b0;
        unique case (state)
            HOLD_EMPTY: begin
                if (in_valid) state_nx = HOLD_FULL;   // prime
            end
            HOLD_FULL: begin
                fire = in_valid;                       // emit
            end
        endcase
    end

    // held word, replaced on every accepted strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            held_data  <= '0;
            held_phase <= '0;
        end else if (in_valid) begin
            held_data  <= in_data;
            held_phase <= in_phase;
        end
    end
endmodule

// File: rtl/bbvote_lane.sv
`timescale 1ns/1ps
module bbvote_lane (
    input  logic d_here,
    input  logic d_next,
    input  logic edge_s,
    output logic early,
    output logic late
);
    logic toggles;
    always_comb begin
        toggles = d_here ^ d_next;
        early   = toggles & (edge_s == d_here);
        late    = toggles & (edge_s == d_next);
    end
endmodule

// File: rtl/bbvote_encode.sv
`timescale 1ns/1ps
module bbvote_encode #(
    parameter int LANES = 4,
    parameter int CNT_W = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0] early_vec,
    input  logic [LANES-1:0] late_vec,
    output logic [CNT_W:0]   code
);
    logic [CNT_W-1:0] n_early;
    logic [CNT_W-1:0] n_late;
    logic             negative;
    logic [CNT_W-1:0] mag;

    always_comb begin
        n_early = '0;
        n_late  = '0;
        for (int i = 0; i < LANES; i++) begin
            n_early = n_early + CNT_W'(early_vec[i]);
            n_late  = n_late  + CNT_W'(late_vec[i]);
        end
        negative = (n_late > n_early);
        mag      = negative ? (n_late - n_early) : (n_early - n_late);
        code     = {negative, mag};
    end
endmodule

// File: rtl/bbvote_detector.sv
`timescale 1ns/1ps
module bbvote_detector
    import bbvote_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [LANES-1:0]           in_data,
    input  logic [LANES-1:0]           in_phase,
    output logic                       vote_valid,
    output logic [$clog2(LANES+1):0]   vote_code
);
    localparam int CNT_W  = $clog2(LANES + 1);
    localparam int CODE_W = CNT_W + 1;

    logic [LANES-1:0]  held_data;
    logic [LANES-1:0]  held_phase;
    hold_state_t       hold_st;
    logic              fire;
    logic [LANES-1:0]  early_vec;
    logic [LANES-1:0]  late_vec;
    logic [CODE_W-1:0] code_nx;

    bbvote_hold #(.LANES(LANES)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_phase   (in_phase),
        .held_data  (held_data),
        .held_phase (held_phase),
        .state      (hold_st),
        .fire       (fire)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic nxt;
        if (g == LANES - 1) begin : g_wrap
            assign nxt = in_data[0];
        end else begin : g_inner
            assign nxt = held_data[g+1];
        end
        bbvote_lane u_lane (
            .d_here (held_data[g]),
            .d_next (nxt),
            .edge_s (held_phase[g]),
            .early  (early_vec[g]),
            .late   (late_vec[g])
        );
    end

    bbvote_encode #(.LANES(LANES), .CNT_W(CNT_W)) u_enc (
        .early_vec (early_vec),
        .late_vec  (late_vec),
        .code      (code_nx)
    );

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            vote_valid <= 1'b0;
            vote_code  <= '0;
        end else begin
            vote_valid <= fire;
            if (fire) vote_code <= code_nx;
        end
    end
endmodule

// File: rtl/bbvote_checker.sv
`timescale 1ns/1ps
module bbvote_checker
    import bbvote_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     vote_valid,
    input logic [$clog2(LANES+1):0] vote_code,
    input hold_state_t              hold_st
);
    localparam int CNT_W = $clog2(LANES + 1);

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!vote_valid && vote_code == '0 && hold_st == HOLD_EMPTY));

    a_r2_prime_silent: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid) && $past(hold_st) == HOLD_EMPTY) |-> !vote_valid);

    a_r2_prime_advance: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid) && !$past(rst)) |-> hold_st == HOLD_FULL);

    a_r3_valid_cause: assert property (@(posedge clk) disable iff (rst)
        vote_valid |-> ($past(in_valid) && $past(hold_st) == HOLD_FULL));

    a_r3_emit_next: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid) && $past(hold_st) == HOLD_FULL && !$past(rst)) |-> vote_valid);

    a_r8_no_neg_zero: assert property (@(posedge clk) disable iff (rst)
        vote_code != {1'b1, {CNT_W{1'b0}}});

    a_r9_code_hold: assert property (@(posedge clk) disable iff (rst)
        !vote_valid |-> $stable(vote_code));

    a_r10_mag_range: assert property (@(posedge clk) disable iff (rst)
        vote_code[CNT_W-1:0] <= CNT_W'(LANES));
endmodule

bind bbvote_detector bbvote_checker #(.LANES(LANES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .vote_valid (vote_valid),
    .vote_code  (vote_code),
    .hold_st    (hold_st)
);

// File: tb/bbvote_detector_bench.sv
`timescale 1ns/1ps
module bbvote_detector_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [3:0] in_data = '0;
    logic [3:0] in_phase = '0;
    logic       vote_valid;
    logic [3:0] vote_code;

    int total = 0;
    int bad = 0;
    bit primed = 1'b0;
    bit done = 1'b0;
    logic [3:0] prev_d = '0;
    logic [3:0] prev_p = '0;
    logic [3:0] last_code = '0;

    always #2.5 clk = ~clk;

    bbvote_detector u_bbvote_detector (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_phase   (in_phase),
        .vote_valid (vote_valid),
        .vote_code  (vote_code)
    );

    function automatic logic [3:0] model(input logic [3:0] d, input logic [3:0] p, input logic nb);
        int net = 0;
        for (int i = 0; i < 4; i++) begin
            logic dn;
            dn = (i == 3) ? nb : d[i+1];
            if (d[i] != dn) begin
                if (p[i] == d[i]) net = net + 1;
                else              net = net - 1;
            end
        end
        if (net < 0) return {1'b1, 3'(-net)};
        return {1'b0, 3'(net)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        primed = 1'b0;
        last_code = '0;
        @(negedge clk);
        check(vote_valid == 1'b0, "R1 valid", int'(vote_valid), 0);
        check(vote_code == 4'b0000, "R1 code", int'(vote_code), 0);
    endtask

    task automatic send(input logic [3:0] d, input logic [3:0] p, input string req);
        logic [3:0] exp;
        in_valid = 1'b1;
        in_data  = d;
        in_phase = p;
        @(negedge clk);
        if (primed) begin
            exp = model(prev_d, prev_p, d[0]);
            check(vote_valid == 1'b1, "R3 valid", int'(vote_valid), 1);
            check(vote_code == exp, req, int'(vote_code), int'(exp));
            last_code = exp;
        end else begin
            check(vote_valid == 1'b0, "R2 prime", int'(vote_valid), 0);
        end
        prev_d = d;
        prev_p = p;
        primed = 1'b1;
        in_valid = 1'b0;
    endtask

    task automatic expect_code(input logic [3:0] want, input string req);
        check(vote_code == want, req, int'(vote_code), int'(want));
    endtask

    task automatic idle(input logic [3:0] junk);
        in_valid = 1'b0;
        in_data  = junk;
        in_phase = ~junk;
        @(negedge clk);
        check(vote_valid == 1'b0, "R9 idle valid", int'(vote_valid), 0);
        check(vote_code == last_code, "R9 idle code", int'(vote_code), int'(last_code));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R3 watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // all lanes toggle, edges match earlier sample: +4
        send(4'b0101, 4'b0101, "R2");
        send(4'b0101, 4'b1010, "R4");
        expect_code(4'b0100, "R4 plus4");
        // all lanes toggle, edges match later sample: -4
        send(4'b0101, 4'b0000, "R5");
        expect_code(4'b1100, "R5 minus4");
        // mixed: -1 then no transitions
        send(4'b0000, 4'b0110, "R8");
        expect_code(4'b1001, "R8 minus1");
        send(4'b0000, 4'b1000, "R6");
        expect_code(4'b0000, "R6 silent");
        // boundary-only transition, edge late
        send(4'b0001, 4'b0000, "R7");
        expect_code(4'b1001, "R7 boundary late");
        // 0001/0000 next 0: lane0 late only
        send(4'b0000, 4'b0000, "R5");
        expect_code(4'b1001, "R5 lane0 late");
        // boundary-only transition, edge early
        send(4'b0001, 4'b0101, "R7");
        expect_code(4'b0001, "R7 boundary early");
        idle(4'b1010);
        idle(4'b0110);
        // near-exhaustive sweep with idle gaps
        for (int k = 0; k < 1024; k++) begin
            logic [3:0] d;
            d = 4'(k);
            d[0] = d[0] ^ k[8] ^ k[9];
            send(d, 4'(k >> 4), "R4 sweep");
            check(vote_code[2:0] <= 3'd4 || !primed, "R10", int'(vote_code[2:0]), 4);
            if (k % 7 == 3) idle(4'(k * 3));
        end
        // reset mid-stream restarts priming
        do_reset();
        send(4'b1010, 4'b1111, "R2");
        idle(4'b0011);
        send(4'b0000, 4'b0000, "R3");
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule